// File: doc/BRIEF.md
# SDRAM Command Decoder and Sequence Checker

This block watches the control pins of a single-rank SDRAM on every rising clock edge. It turns each sample into one command code and reports the bank, all-banks and auto-precharge flags and the row or column address that go with it. A small open/closed record for each of the four banks lets it check each command against the bank state and the recent command history. When a command breaks a sequencing rule, the matching violation flag pulses for one cycle alongside the decoded command.

Its place is next to a memory controller, either as a protocol monitor or as a front end for a bus analyser. Every output is registered, so a sample taken at edge k appears on the outputs just after edge k and stays until edge k+1. The per-bank record follows every decoded command, including one that is flagged. A controlling state machine, the sequence guard, owns the two sequencing rules that depend on history. It has four states:
- G_IDLE: no lockout is active.
- G_MRS1 and G_MRS2: the two cycles after a mode-register load.
- G_BURST: an auto-precharge burst is in progress.

It has these transitions:
- G_IDLE to G_MRS1 on a mode-register load.
- G_IDLE to G_BURST on a legal read or write with auto precharge, when BURST_LEN is greater than 1.
- G_MRS1 to G_MRS2 and G_MRS2 to G_IDLE, unconditionally.
- G_BURST to G_MRS1 on a mode-register load.
- G_BURST to G_IDLE on a burst stop, or once the burst count runs out.

Top module: `sdram_cmd_chk`

## Requirements
- R1: The command codes are NOP=0, MRS (mode register load)=1, REF (auto refresh)=2, SREF (self-refresh entry)=3, ACT=4, RD=5, WR=6, BST (burst stop)=7 and PRE=8. With cs_n high the code is NOP. With cs_n low, ras_n/cas_n/we_n decode as follows: 000 is MRS, 011 is ACT, 101 is RD, 100 is WR, 110 is BST, 010 is PRE and 111 is NOP.
- R2: When cs_n is low and ras_n/cas_n/we_n is 001, the code is REF if cke_prev and cke are both high. It is SREF if cke_prev is high and cke is low. It is NOP if cke_prev is low.
- R3: bank_o gives the bank number 0..3. A ba of 00 maps to 0, 01 to 2, 10 to 1 and 11 to 3. On PRE with addr[10] high, all_banks_o is 1 and bank_o is 0. all_banks_o is 0 for every other command.
- R4: auto_pre_o is 1 only on RD or WR with addr[10] high. row_o carries addr on ACT and is 0 otherwise. col_o carries addr[8:0] on RD and WR and is 0 otherwise.
- R5: The outputs for the sample taken at edge k are valid from just after edge k. In reset all outputs are 0, all banks are closed and no lockout is active.
- R6: viol_allpre_o pulses when MRS, REF or SREF is decoded while any bank is open.
- R7: The two samples after a mode-register load must be NOP. Any other code in either of them pulses viol_mrs_o, and the lockout still ends after those two samples.
- R8: ACT opens its bank. PRE closes its bank, or all banks when all_banks_o is set. RD or WR with auto precharge to an open bank closes that bank. viol_closed_o pulses on RD or WR to a closed bank.
- R9: A RD or WR with auto precharge to an open bank, with no guard lockout active, starts a burst. Any RD or WR in the next BURST_LEN-1 samples pulses viol_burst_o, and those commands start no new burst.
- R10: A BST during a burst ends it, so a RD or WR in the next sample is not flagged by viol_burst_o. An MRS during a burst ends the burst and starts the mode-register lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_prev | input | 1 | Clock enable from the previous cycle |
| cke | input | 1 | Clock enable in this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address pins |
| addr | input | ADDR_W | Address bus; bit 10 is the precharge and auto-precharge select |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Target bank number |
| all_banks_o | output | 1 | Precharge applies to all banks |
| auto_pre_o | output | 1 | Read or write requests auto precharge |
| row_o | output | ADDR_W | Row address on ACT |
| col_o | output | COL_W | Column address on RD or WR |
| viol_allpre_o | output | 1 | Command needs all banks closed, but a bank is open |
| viol_mrs_o | output | 1 | Non-NOP command inside the mode-register lockout |
| viol_closed_o | output | 1 | Read or write to a closed bank |
| viol_burst_o | output | 1 | Read or write during an auto-precharge burst |

## Verification
The bench builds the block with BURST_LEN set to 4 and the other parameters at their defaults. A burst of four lets short directed sequences reach every lockout case. These cases include a read or write in the last blocked sample, the first free sample after the count runs out, a burst stop in mid-burst, and a mode-register load that cuts a burst short. A long weighted random phase follows. It mixes bank activity with refresh and mode-register commands, so lockouts, closed-bank accesses and open-bank refreshes overlap in combinations that the directed part does not list.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_REF  = 4'd2,
        CMD_SREF = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_RD   = 4'd5,
        CMD_WR   = 4'd6,
        CMD_BST  = 4'd7,
        CMD_PRE  = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        G_IDLE  = 2'd0,
        G_MRS1  = 2'd1,
        G_MRS2  = 2'd2,
        G_BURST = 2'd3
    } guard_e;

    localparam int BANK_W = 2;
    localparam int NUM_BANKS = 1 << BANK_W;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  logic              cke_prev,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] bank,
    output logic              all_b,
    output logic              ap
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: cmd = CMD_MRS;
                3'b001: begin
                    if (cke_prev) cmd = cke ? CMD_REF : CMD_SREF;
                end
                3'b011: cmd = CMD_ACT;
                3'b101: cmd = CMD_RD;
                3'b100: cmd = CMD_WR;
                3'b110: cmd = CMD_BST;
                3'b010: cmd = CMD_PRE;
                3'b111: cmd = CMD_NOP;
            endcase
        end
    end

    // Pin pair is swapped: ba0 carries the high bank-number bit.
    assign bank  = {ba[0], ba[1]};
    assign all_b = (cmd == CMD_PRE) && addr[AP_BIT];
    assign ap    = ((cmd == CMD_RD) || (cmd == CMD_WR)) && addr[AP_BIT];

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_chk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_e                 cmd,
    input  logic [BANK_W-1:0]    bank,
    input  logic                 all_b,
    input  logic                 ap,
    output logic [NUM_BANKS-1:0] open_q
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank == BANK_W'(b));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
            end else if (cmd == CMD_ACT && hit) begin
                open_q[b] <= 1'b1;
            end else if (cmd == CMD_PRE && (all_b || hit)) begin
                open_q[b] <= 1'b0;
            end else if ((cmd == CMD_RD || cmd == CMD_WR) && ap && hit) begin
                open_q[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdram_seq_guard.sv
module sdram_seq_guard
    import sdram_chk_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic ap,
    input  logic bank_closed,
    output logic viol_mrs,
    output logic viol_burst
);

    localparam int CNT_W = $clog2(BURST_LEN + 1);

    guard_e            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              is_rw, starts;

    assign is_rw  = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign starts = is_rw && ap && !bank_closed && (BURST_LEN > 1);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            G_IDLE: begin
                if (cmd == CMD_MRS) begin
                    state_d = G_MRS1;
                end else if (starts) begin
                    state_d = G_BURST;
                    cnt_d   = CNT_W'(BURST_LEN - 1);
                end
            end
            G_MRS1: state_d = G_MRS2;
            G_MRS2: state_d = G_IDLE;
            G_BURST: begin
                if (cmd == CMD_MRS) begin
                    state_d = G_MRS1;
                end else if (cmd == CMD_BST || cnt_q == CNT_W'(1)) begin
                    state_d = G_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= G_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        viol_mrs   = 1'b0;
        viol_burst = 1'b0;
        unique case (state_q)
            G_IDLE:  ;
            G_MRS1,
            G_MRS2:  viol_mrs   = (cmd != CMD_NOP);
            G_BURST: viol_burst = is_rw;
        endcase
    end

endmodule

// File: rtl/sdram_cmd_chk.sv
module sdram_cmd_chk
    import sdram_chk_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_prev,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cmd_o,
    output logic [1:0]        bank_o,
    output logic              all_banks_o,
    output logic              auto_pre_o,
    output logic [ADDR_W-1:0] row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              viol_allpre_o,
    output logic              viol_mrs_o,
    output logic              viol_closed_o,
    output logic              viol_burst_o
);

    cmd_e                 cmd;
    logic [BANK_W-1:0]    bank;
    logic                 all_b, ap;
    logic [NUM_BANKS-1:0] open_q;
    logic                 is_rw, needs_idle, closed, v_mrs, v_burst;

    sdram_cmd_decode #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_dec (
        .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd(cmd), .bank(bank), .all_b(all_b), .ap(ap)
    );

    sdram_bank_track u_banks (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
        .all_b(all_b), .ap(ap), .open_q(open_q)
    );

    assign is_rw      = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign needs_idle = (cmd == CMD_MRS) || (cmd == CMD_REF) || (cmd == CMD_SREF);
    assign closed     = is_rw && !open_q[bank];

    sdram_seq_guard #(.BURST_LEN(BURST_LEN)) u_guard (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ap(ap),
        .bank_closed(closed), .viol_mrs(v_mrs), .viol_burst(v_burst)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o         <= 4'd0;
            bank_o        <= '0;
            all_banks_o   <= 1'b0;
            auto_pre_o    <= 1'b0;
            row_o         <= '0;
            col_o         <= '0;
            viol_allpre_o <= 1'b0;
            viol_mrs_o    <= 1'b0;
            viol_closed_o <= 1'b0;
            viol_burst_o  <= 1'b0;
        end else begin
            cmd_o         <= cmd;
            bank_o        <= all_b ? '0 : bank;
            all_banks_o   <= all_b;
            auto_pre_o    <= ap;
            row_o         <= (cmd == CMD_ACT) ? addr : '0;
            col_o         <= is_rw ? addr[COL_W-1:0] : '0;
            viol_allpre_o <= needs_idle && (|open_q);
            viol_mrs_o    <= v_mrs;
            viol_closed_o <= closed;
            viol_burst_o  <= v_burst;
        end
    end

endmodule

// File: rtl/sdram_cmd_chk_sva.sv
module sdram_cmd_chk_sva #(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd_o,
    input logic              all_banks_o,
    input logic              auto_pre_o,
    input logic [ADDR_W-1:0] row_o,
    input logic              viol_allpre_o,
    input logic              viol_mrs_o,
    input logic              viol_closed_o,
    input logic              viol_burst_o
);

    p_allb_only_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
        all_banks_o |-> cmd_o == 4'd8);

    p_ap_only_rw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> (cmd_o == 4'd5 || cmd_o == 4'd6));

    p_row_only_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 4'd4) |-> row_o == '0);

    p_allpre_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        viol_allpre_o |-> (cmd_o == 4'd1 || cmd_o == 4'd2 || cmd_o == 4'd3));

    p_mrs_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd1 && !viol_mrs_o) |=> (viol_mrs_o == (cmd_o != 4'd0)));

    p_mrs_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        viol_mrs_o |-> cmd_o != 4'd0);

    p_closed_rw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_closed_o |-> (cmd_o == 4'd5 || cmd_o == 4'd6));

    p_burst_rw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_burst_o |-> (cmd_o == 4'd5 || cmd_o == 4'd6));

    p_lock_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({viol_mrs_o, viol_burst_o}));

    p_bst_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd7 && !viol_mrs_o) |=> !viol_burst_o);

endmodule

bind sdram_cmd_chk sdram_cmd_chk_sva #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .all_banks_o(all_banks_o),
    .auto_pre_o(auto_pre_o), .row_o(row_o), .viol_allpre_o(viol_allpre_o),
    .viol_mrs_o(viol_mrs_o), .viol_closed_o(viol_closed_o),
    .viol_burst_o(viol_burst_o)
);

// File: tb/tb_sdram_cmd_chk.sv
module tb_sdram_cmd_chk;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int COL_W  = 9;
    localparam int BL     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_prev = 1'b1, cke = 1'b1, cs_n = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic all_banks_o, auto_pre_o;
    logic [ADDR_W-1:0] row_o;
    logic [COL_W-1:0] col_o;
    logic viol_allpre_o, viol_mrs_o, viol_closed_o, viol_burst_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(10), .BURST_LEN(BL)) dut (
        .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_o(cmd_o), .bank_o(bank_o), .all_banks_o(all_banks_o),
        .auto_pre_o(auto_pre_o), .row_o(row_o), .col_o(col_o),
        .viol_allpre_o(viol_allpre_o), .viol_mrs_o(viol_mrs_o),
        .viol_closed_o(viol_closed_o), .viol_burst_o(viol_burst_o)
    );

    // reference model state
    bit bank_open [4];
    int mrs_left = 0;
    int burst_left = 0;
    // expected outputs for the last driven sample
    int e_cmd, e_bank, e_row, e_col;
    bit e_allb, e_ap, e_vall, e_vmrs, e_vcl, e_vbu;
    bit have_exp = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 cmd", cmd_o, e_cmd);
        chk("R3 bank", bank_o, e_bank);
        chk("R3 all_banks", all_banks_o, e_allb);
        chk("R4 auto_pre", auto_pre_o, e_ap);
        chk("R4 row", row_o, e_row);
        chk("R4 col", col_o, e_col);
        chk("R6 viol_allpre", viol_allpre_o, e_vall);
        chk("R7 viol_mrs", viol_mrs_o, e_vmrs);
        chk("R8 viol_closed", viol_closed_o, e_vcl);
        chk("R9 viol_burst", viol_burst_o, e_vbu);
    endtask

    task automatic model(input bit cp, input bit ck, input bit cs, input bit r,
                         input bit c, input bit w, input logic [1:0] b,
                         input logic [ADDR_W-1:0] a);
        int cmd, bk;
        bit any_open, rw;
        cmd = 0;
        if (!cs) begin
            if (!r && !c && !w) cmd = 1;
            else if (!r && !c && w) cmd = !cp ? 0 : (ck ? 2 : 3);
            else if (!r && c && w) cmd = 4;
            else if (r && !c && w) cmd = 5;
            else if (r && !c && !w) cmd = 6;
            else if (r && c && !w) cmd = 7;
            else if (!r && c && !w) cmd = 8;
        end
        bk = (b == 2'b01) ? 2 : (b == 2'b10) ? 1 : int'(b);
        rw = (cmd == 5 || cmd == 6);
        any_open = bank_open[0] | bank_open[1] | bank_open[2] | bank_open[3];
        e_cmd  = cmd;
        e_allb = (cmd == 8) && a[10];
        e_bank = e_allb ? 0 : bk;
        e_ap   = rw && a[10];
        e_row  = (cmd == 4) ? int'(a) : 0;
        e_col  = rw ? int'(a[COL_W-1:0]) : 0;
        e_vall = (cmd >= 1 && cmd <= 3) && any_open;
        e_vmrs = (mrs_left > 0) && (cmd != 0);
        e_vbu  = (mrs_left == 0) && (burst_left > 0) && rw;
        e_vcl  = rw && !bank_open[bk];
        // sequence state
        if (mrs_left > 0) mrs_left--;
        else if (cmd == 1) begin mrs_left = 2; burst_left = 0; end
        else if (burst_left > 0) begin
            if (cmd == 7) burst_left = 0;
            else burst_left--;
        end else if (e_ap && !e_vcl && BL > 1) burst_left = BL - 1;
        // bank state
        if (cmd == 4) bank_open[bk] = 1;
        else if (cmd == 8) begin
            if (e_allb) for (int i = 0; i < 4; i++) bank_open[i] = 0;
            else bank_open[bk] = 0;
        end else if (e_ap) bank_open[bk] = 0;
    endtask

    task automatic drive(input bit cs, input logic [2:0] rcw, input logic [1:0] b,
                         input logic [ADDR_W-1:0] a, input bit cp = 1, input bit ck = 1);
        @(negedge clk);
        if (have_exp) compare_all();
        cs_n = cs; ras_n = rcw[2]; cas_n = rcw[1]; we_n = rcw[0];
        ba = b; addr = a; cke_prev = cp; cke = ck;
        model(cp, ck, cs, rcw[2], rcw[1], rcw[0], b, a);
        have_exp = 1;
    endtask

    task automatic nop();                          drive(0, 3'b111, 2'b00, '0); endtask
    task automatic act(input logic [1:0] b, input int row);  drive(0, 3'b011, b, ADDR_W'(row)); endtask
    task automatic rd(input logic [1:0] b, input bit ap, input int col);
        drive(0, 3'b101, b, ADDR_W'(col) | (ap ? 12'h400 : 12'h000));
    endtask
    task automatic wr(input logic [1:0] b, input bit ap, input int col);
        drive(0, 3'b100, b, ADDR_W'(col) | (ap ? 12'h400 : 12'h000));
    endtask
    task automatic pre(input logic [1:0] b, input bit all);
        drive(0, 3'b010, b, all ? 12'h400 : 12'h000);
    endtask
    task automatic mrs();                          drive(0, 3'b000, 2'b00, 12'h032); endtask
    task automatic bst();                          drive(0, 3'b110, 2'b00, '0); endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R5: reset state
        chk("R5 reset cmd", cmd_o, 0);
        chk("R5 reset viol", {viol_allpre_o, viol_mrs_o, viol_closed_o, viol_burst_o}, 0);
        chk("R5 reset row", row_o, 0);
        rst_n = 1'b1;
        // R1 deselect, NOP and idle refresh; R2 clock-enable variants
        drive(1, 3'b000, 2'b00, '0);
        nop();
        drive(0, 3'b001, 2'b00, '0, 1, 1);   // REF
        drive(0, 3'b001, 2'b00, '0, 1, 0);   // SREF
        drive(0, 3'b001, 2'b00, '0, 0, 1);   // NOP
        // R7 mode-register lockout: clean, then violated
        mrs(); nop(); nop(); act(2'b00, 5);
        pre(2'b00, 0);
        mrs(); act(2'b01, 7); bst(); nop();
        pre(2'b00, 1);
        // R3 bank mapping, R8 closed-bank access
        rd(2'b11, 0, 3);
        act(2'b01, 12'h123); act(2'b10, 12'h0ff); act(2'b11, 1);
        rd(2'b01, 0, 9); wr(2'b10, 0, 12'h1ff);
        // R6 refresh and mode load with banks open
        drive(0, 3'b001, 2'b00, '0);
        mrs(); nop(); nop();
        // R9 auto-precharge burst, blocked in every window sample, free after
        wr(2'b01, 1, 4); rd(2'b10, 0, 1); wr(2'b11, 0, 2); rd(2'b10, 0, 3);
        rd(2'b10, 0, 4);
        // R10 burst stop ends the burst early
        rd(2'b10, 1, 6); nop(); bst(); wr(2'b11, 0, 8);
        // R10 mode load during a burst
        act(2'b00, 9); rd(2'b00, 1, 1); mrs(); nop(); rd(2'b11, 0, 0); nop();
        // R8 precharge of one bank then all banks
        pre(2'b11, 0); rd(2'b11, 0, 1);
        act(2'b01, 3); pre(2'b10, 1); wr(2'b01, 0, 2);
        // R8 auto-precharge access to a closed bank starts no burst
        rd(2'b01, 1, 1); rd(2'b01, 0, 1);
        // weighted random mix
        for (int n = 0; n < 2000; n++) begin
            int sel;
            logic [2:0] rcw;
            sel = $urandom % 16;
            rcw = (sel < 4) ? 3'b011 : (sel < 7) ? 3'b101 : (sel < 9) ? 3'b100 :
                  (sel < 11) ? 3'b010 : (sel == 11) ? 3'b110 : (sel == 12) ? 3'b000 :
                  (sel == 13) ? 3'b001 : 3'b111;
            drive(($urandom % 10) == 0, rcw, 2'($urandom), ADDR_W'($urandom),
                  ($urandom % 6) != 0, ($urandom % 4) != 0);
        end
        nop();
        nop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule